// File: doc/BRIEF.md
# Processor trap entry sequencer

This block does the hardware half of trap and reset handling in a windowed-register processor. It owns a small set of processor state: a trap-enable bit, the current and previous supervisor bits, the current window pointer, and a trap base register. The trap base register combines a software-loaded base address with a cause-code field. When the pipeline raises a trap request, the block makes only reversible changes to that state. It decrements the window pointer into a fresh trap window, ships the interrupted program counter pair out to be written into the new window, and sends fetch to the vector address. The prior state is never saved as a whole. A return request undoes the changes.

There are three classes of request. A reset request always wins and restarts fetch at address zero. A synchronous trap is caused by the instruction in flight; a misaligned access is one of these. An asynchronous trap comes from an external event. While traps are disabled, an asynchronous request is dropped. A synchronous request in the same situation halts the block in a sticky error mode that only a reset request clears.

The captured program counter pair leaves on a valid/ready stream. The payload stays put until the consumer takes it. While a capture is outstanding, `cap_valid` doubles as a stall: every trap and return request is refused. A reset request is still taken, and it discards the pending capture.

Top module: `trap_entry_seq`

## Requirements
- R1: While `rst_n` is low: `et`=0, `s_mode`=1, `ps_mode`=0, `cwp`=0, `tbr`=0, `err_mode`=0, `redir_valid`=0 and `cap_valid`=0.
- R2: On a taken trap, the outputs one cycle later show `et`=0, `ps_mode` equal to the old `s_mode`, and `s_mode`=1.
- R3: A taken trap decrements `cwp` by one modulo NWIN, so 0 becomes NWIN-1.
- R4: A taken trap writes the cause code into `tbr[11:4]`. `tbr[3:0]` stays 0 and `tbr[31:12]` keeps the base. One cycle later, `redir_valid` pulses for exactly one cycle with `redir_pc` equal to the new `tbr` and `redir_npc` equal to `redir_pc`+4.
- R5: A taken trap raises `cap_valid` one cycle later. The payload is `cap_win` equal to the new `cwp`, and `cap_pc`/`cap_npc` equal to the `pc_in`/`npc_in` seen with the request. The payload is held stable until a cycle with `cap_ready` high. While `cap_valid` is high, trap and return requests are ignored.
- R6: `reset_req` has priority over every other request. One cycle later: `et`=0, `s_mode`=1, `err_mode`=0, and a one-cycle redirect to pc 0 / npc 4. `cwp`, `ps_mode` and `tbr` keep their values, and any pending capture is dropped.
- R7: When `et` is 0, `async_req` causes no state change and no redirect.
- R8: A synchronous request (`misalign` or `sync_req`) with `et`=0 and no capture pending sets `err_mode`. The state is otherwise unchanged and there is no redirect. `err_mode` stays high, and all other requests and base writes are ignored, until `reset_req` or `rst_n`.
- R9: Synchronous requests rank above asynchronous ones. `misalign` ranks above `sync_req` and uses cause code 7; otherwise the cause is `sync_tt` or `async_tt`.
- R10: `ret_req` with nothing of higher rank increments `cwp` modulo NWIN (NWIN-1 becomes 0), copies `ps_mode` into `s_mode` and sets `et`.
- R11: `tba_wr` loads `tba_in` into `tbr[31:12]` only in a cycle where no reset, trap, error entry or return is taken, and not in error mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reset_req | input | 1 | Reset trap request |
| misalign | input | 1 | Misaligned access (synchronous, cause 7) |
| sync_req | input | 1 | Other synchronous trap request |
| sync_tt | input | 8 | Cause code for `sync_req` |
| async_req | input | 1 | Asynchronous trap request |
| async_tt | input | 8 | Cause code for `async_req` |
| ret_req | input | 1 | Return-from-trap request |
| tba_wr | input | 1 | Load trap base |
| tba_in | input | 20 | New trap base (address bits 31:12) |
| pc_in | input | 32 | Current program counter |
| npc_in | input | 32 | Current next program counter |
| et | output | 1 | Trap enable |
| s_mode | output | 1 | Supervisor bit |
| ps_mode | output | 1 | Previous supervisor bit |
| cwp | output | 3 | Current window pointer |
| tbr | output | 32 | Trap base register {base, cause, 4'b0} |
| err_mode | output | 1 | Sticky error mode |
| redir_valid | output | 1 | One-cycle fetch redirect strobe |
| redir_pc | output | 32 | Redirect program counter |
| redir_npc | output | 32 | Redirect next program counter |
| cap_valid | output | 1 | Captured pair valid (also stall) |
| cap_ready | input | 1 | Consumer accepts captured pair |
| cap_win | output | 3 | Window that receives the pair |
| cap_pc | output | 32 | Captured program counter |
| cap_npc | output | 32 | Captured next program counter |

## Verification
Every request acts on the very next clock edge, so any wrong internal state shows up at the ports one cycle after the request that caused it. The symptoms are a misplaced `cwp`, a wrong cause in `tbr[11:4]`, or a redirect strobe that is missing, extra or pointed at the wrong address. A mis-ranked request shows up just as fast as the wrong cause code or a missing redirect. A stale mode bit can stay hidden until the next return request copies `ps_mode` back, so the tests chain several traps and returns. A bad window count is only visible at the wrap points, so the tests drive `cwp` through both 0→NWIN-1 and NWIN-1→0. A capture that is lost or duplicated is seen at the handshake after its trap.

// File: rtl/trap_seq_pkg.sv
`timescale 1ns/1ps
package trap_seq_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_RESET,
    EV_TRAP,
    EV_ERROR,
    EV_RETURN,
    EV_HOLD
  } trap_ev_e;

  localparam int CAUSE_MISALIGN = 7;
  localparam int VEC_SHIFT      = 4;
endpackage

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter
  import trap_seq_pkg::*;
#(
  parameter int TTW = 8
) (
  input  logic           reset_req,
  input  logic           err_mode,
  input  logic           stall,
  input  logic           et,
  input  logic           misalign,
  input  logic           sync_req,
  input  logic [TTW-1:0] sync_tt,
  input  logic           async_req,
  input  logic [TTW-1:0] async_tt,
  input  logic           ret_req,
  output trap_ev_e       ev,
  output logic [TTW-1:0] cause
);
  logic sync_any;
  assign sync_any = misalign | sync_req;

  always_comb begin
    ev    = EV_NONE;
    cause = async_tt;
    if (reset_req) begin
      ev = EV_RESET;
    end else if (err_mode) begin
      ev = EV_HOLD;
    end else if (stall) begin
      ev = EV_NONE;
    end else if (sync_any) begin
      ev    = et ? EV_TRAP : EV_ERROR;
      cause = misalign ? TTW'(CAUSE_MISALIGN) : sync_tt;
    end else if (async_req && et) begin
      ev    = EV_TRAP;
      cause = async_tt;
    end else if (ret_req) begin
      ev = EV_RETURN;
    end
  end
endmodule

// File: rtl/trap_mode_regs.sv
`timescale 1ns/1ps
module trap_mode_regs
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  parameter int TTW  = 8,
  localparam int CWPW = $clog2(NWIN),
  localparam int BLSB = TTW + VEC_SHIFT,
  localparam int BW   = AW - BLSB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trap_ev_e        ev,
  input  logic [TTW-1:0]  cause,
  input  logic            tba_wr,
  input  logic [BW-1:0]   tba_in,
  output logic            et,
  output logic            s_mode,
  output logic            ps_mode,
  output logic [CWPW-1:0] cwp,
  output logic [AW-1:0]   tbr,
  output logic [AW-1:0]   vec_addr,
  output logic            err_mode
);
  localparam logic [CWPW-1:0] WTOP = CWPW'(NWIN - 1);

  logic            et_q, s_q, ps_q, err_q;
  logic [CWPW-1:0] cwp_q, cwp_dn, cwp_up;
  logic [BW-1:0]   tba_q;
  logic [TTW-1:0]  tt_q;

  assign cwp_dn = (cwp_q == '0)  ? WTOP : cwp_q - 1'b1;
  assign cwp_up = (cwp_q == WTOP) ? '0  : cwp_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      et_q  <= 1'b0;
      s_q   <= 1'b1;
      ps_q  <= 1'b0;
      err_q <= 1'b0;
      cwp_q <= '0;
      tba_q <= '0;
      tt_q  <= '0;
    end else begin
      case (ev)
        EV_RESET: begin
          et_q  <= 1'b0;
          s_q   <= 1'b1;
          err_q <= 1'b0;
        end
        EV_TRAP: begin
          et_q  <= 1'b0;
          ps_q  <= s_q;
          s_q   <= 1'b1;
          cwp_q <= cwp_dn;
          tt_q  <= cause;
        end
        EV_ERROR: err_q <= 1'b1;
        EV_RETURN: begin
          et_q  <= 1'b1;
          s_q   <= ps_q;
          cwp_q <= cwp_up;
        end
        EV_NONE: if (tba_wr) tba_q <= tba_in;
        default: ;
      endcase
    end
  end

  assign et       = et_q;
  assign s_mode   = s_q;
  assign ps_mode  = ps_q;
  assign cwp      = cwp_q;
  assign err_mode = err_q;
  assign tbr      = {tba_q, tt_q, {VEC_SHIFT{1'b0}}};
  assign vec_addr = {tba_q, cause, {VEC_SHIFT{1'b0}}};

  AST_TRAP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP) |=> (!et_q && s_q && ps_q == $past(s_q))); // R2

  AST_WINDOW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TRAP) |=> (cwp_q == (($past(cwp_q) == '0) ? WTOP : $past(cwp_q) - 1'b1))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && ev != EV_RESET) |=> err_q); // R8

  AST_RESET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RESET) |=> ($stable(cwp_q) && $stable(tba_q) && $stable(ps_q) && !err_q)); // R6
endmodule

// File: rtl/trap_capture.sv
`timescale 1ns/1ps
module trap_capture #(
  parameter int AW   = 32,
  parameter int CWPW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            drop,
  input  logic [CWPW-1:0] win_in,
  input  logic [AW-1:0]   pc_in,
  input  logic [AW-1:0]   npc_in,
  input  logic            cap_ready,
  output logic            cap_valid,
  output logic [CWPW-1:0] cap_win,
  output logic [AW-1:0]   cap_pc,
  output logic [AW-1:0]   cap_npc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_win   <= '0;
      cap_pc    <= '0;
      cap_npc   <= '0;
    end else if (drop) begin
      cap_valid <= 1'b0;
    end else if (load) begin
      cap_valid <= 1'b1;
      cap_win   <= win_in;
      cap_pc    <= pc_in;
      cap_npc   <= npc_in;
    end else if (cap_valid && cap_ready) begin
      cap_valid <= 1'b0;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready && !drop) |=>
      (cap_valid && $stable(cap_win) && $stable(cap_pc) && $stable(cap_npc))); // R5
endmodule

// File: rtl/trap_entry_seq.sv
`timescale 1ns/1ps
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  parameter int TTW  = 8,
  localparam int CWPW = $clog2(NWIN),
  localparam int BW   = AW - TTW - VEC_SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reset_req,
  input  logic            misalign,
  input  logic            sync_req,
  input  logic [TTW-1:0]  sync_tt,
  input  logic            async_req,
  input  logic [TTW-1:0]  async_tt,
  input  logic            ret_req,
  input  logic            tba_wr,
  input  logic [BW-1:0]   tba_in,
  input  logic [AW-1:0]   pc_in,
  input  logic [AW-1:0]   npc_in,
  output logic            et,
  output logic            s_mode,
  output logic            ps_mode,
  output logic [CWPW-1:0] cwp,
  output logic [AW-1:0]   tbr,
  output logic            err_mode,
  output logic            redir_valid,
  output logic [AW-1:0]   redir_pc,
  output logic [AW-1:0]   redir_npc,
  output logic            cap_valid,
  input  logic            cap_ready,
  output logic [CWPW-1:0] cap_win,
  output logic [AW-1:0]   cap_pc,
  output logic [AW-1:0]   cap_npc
);
  trap_ev_e        ev;
  logic [TTW-1:0]  cause;
  logic [AW-1:0]   vec_addr;
  logic [CWPW-1:0] win_next;
  localparam logic [CWPW-1:0] WTOP = CWPW'(NWIN - 1);

  trap_arbiter #(.TTW(TTW)) u_arb (
    .reset_req (reset_req),
    .err_mode  (err_mode),
    .stall     (cap_valid),
    .et        (et),
    .misalign  (misalign),
    .sync_req  (sync_req),
    .sync_tt   (sync_tt),
    .async_req (async_req),
    .async_tt  (async_tt),
    .ret_req   (ret_req),
    .ev        (ev),
    .cause     (cause)
  );

  trap_mode_regs #(.NWIN(NWIN), .AW(AW), .TTW(TTW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .cause    (cause),
    .tba_wr   (tba_wr),
    .tba_in   (tba_in),
    .et       (et),
    .s_mode   (s_mode),
    .ps_mode  (ps_mode),
    .cwp      (cwp),
    .tbr      (tbr),
    .vec_addr (vec_addr),
    .err_mode (err_mode)
  );

  assign win_next = (cwp == '0) ? WTOP : cwp - 1'b1;

  trap_capture #(.AW(AW), .CWPW(CWPW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev == EV_TRAP),
    .drop      (ev == EV_RESET),
    .win_in    (win_next),
    .pc_in     (pc_in),
    .npc_in    (npc_in),
    .cap_ready (cap_ready),
    .cap_valid (cap_valid),
    .cap_win   (cap_win),
    .cap_pc    (cap_pc),
    .cap_npc   (cap_npc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_npc   <= '0;
    end else begin
      redir_valid <= (ev == EV_RESET) || (ev == EV_TRAP);
      if (ev == EV_RESET) begin
        redir_pc  <= '0;
        redir_npc <= AW'(4);
      end else if (ev == EV_TRAP) begin
        redir_pc  <= vec_addr;
        redir_npc <= vec_addr + AW'(4);
      end
    end
  end

  AST_REDIR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_npc == redir_pc + AW'(4))); // R4

  AST_ASYNC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!et && async_req && !misalign && !sync_req && !reset_req) |=> !redir_valid); // R7

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (redir_valid && redir_pc == '0 && !cap_valid && !et && s_mode)); // R6

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mode && !reset_req) |=> !redir_valid); // R8
endmodule

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 0, misalign = 0, sync_req = 0, async_req = 0, ret_req = 0, tba_wr = 0;
  logic [7:0]  sync_tt = 0, async_tt = 0;
  logic [19:0] tba_in = 0;
  logic [31:0] pc_in = 0, npc_in = 0;
  logic        cap_ready = 0;
  logic        et, s_mode, ps_mode, err_mode, redir_valid, cap_valid;
  logic [2:0]  cwp, cap_win;
  logic [31:0] tbr, redir_pc, redir_npc, cap_pc, cap_npc;

  int n_tests = 0;
  int n_fail  = 0;

  logic        m_et = 0, m_s = 1, m_ps = 0, m_err = 0, m_cv = 0;
  int          m_cwp = 0;
  logic [19:0] m_tba = 0;
  logic [7:0]  m_tt = 0;
  logic [31:0] pc_ctr = 32'h0000_2000;

  logic [63:0] exp_redir[$];
  logic [66:0] exp_cap[$];

  always #2.5 clk = ~clk;

  trap_entry_seq u_trap_entry_seq (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .misalign(misalign),
    .sync_req(sync_req), .sync_tt(sync_tt), .async_req(async_req), .async_tt(async_tt),
    .ret_req(ret_req), .tba_wr(tba_wr), .tba_in(tba_in), .pc_in(pc_in), .npc_in(npc_in),
    .et(et), .s_mode(s_mode), .ps_mode(ps_mode), .cwp(cwp), .tbr(tbr), .err_mode(err_mode),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_win(cap_win),
    .cap_pc(cap_pc), .cap_npc(cap_npc)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Monitor: redirect strobes and capture handshakes against the scoreboard (R4, R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (redir_valid) begin
        if (exp_redir.size() == 0) check("R4", "unexpected redirect", {redir_pc, redir_npc}, 64'h0);
        else check("R4", "redirect pair", {redir_pc, redir_npc}, exp_redir.pop_front());
      end
      if (cap_valid && cap_ready) begin
        if (exp_cap.size() == 0) check("R5", "unexpected capture", {cap_pc, cap_npc}, 64'h0);
        else check("R5", "capture payload", {cap_win, cap_pc, cap_npc}, exp_cap.pop_front());
      end
    end
  end

  task automatic take(input logic [7:0] tt);
    m_cwp = (m_cwp + NW - 1) % NW;
    m_ps  = m_s;
    m_s   = 1'b1;
    m_et  = 1'b0;
    m_tt  = tt;
    m_cv  = 1'b1;
    exp_redir.push_back({m_tba, tt, 4'h0, m_tba, tt, 4'h0} + 64'd4);
    exp_cap.push_back({3'(m_cwp), pc_ctr, pc_ctr + 32'd4});
  endtask

  task automatic drive(input string req, input logic rr, input logic mis, input logic sr,
                       input logic [7:0] stt, input logic ar, input logic [7:0] att,
                       input logic rt, input logic tw, input logic [19:0] ti, input logic rdy);
    logic stall;
    stall = m_cv;
    if (rr) begin
      m_et = 0; m_s = 1; m_err = 0;
      if (m_cv) void'(exp_cap.pop_back());
      m_cv = 0;
      exp_redir.push_back({32'h0, 32'h4});
    end else if (!m_err) begin
      if (m_cv && rdy) m_cv = 0;
      if (stall) begin
        if (tw) m_tba = ti;
      end else if (mis || sr) begin
        if (m_et) take(mis ? 8'd7 : stt);
        else m_err = 1;
      end else if (ar && m_et) begin
        take(att);
      end else if (rt) begin
        m_cwp = (m_cwp + 1) % NW; m_s = m_ps; m_et = 1;
      end else if (tw) begin
        m_tba = ti;
      end
    end
    reset_req = rr; misalign = mis; sync_req = sr; sync_tt = stt;
    async_req = ar; async_tt = att; ret_req = rt; tba_wr = tw; tba_in = ti;
    cap_ready = rdy; pc_in = pc_ctr; npc_in = pc_ctr + 32'd4;
    @(posedge clk); #1;
    pc_ctr = pc_ctr + 32'd8;
    check(req, "et", et, m_et);
    check(req, "s_mode", s_mode, m_s);
    check(req, "ps_mode", ps_mode, m_ps);
    check(req, "cwp", cwp, m_cwp[2:0]);
    check(req, "tbr", tbr, {m_tba, m_tt, 4'h0});
    check(req, "err_mode", err_mode, m_err);
    check(req, "cap_valid", cap_valid, m_cv);
  endtask

  task automatic idle(input string req, input logic rdy);
    drive(req, 0, 0, 0, 8'h0, 0, 8'h0, 0, 0, 20'h0, rdy);
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "et", et, 0);
    check("R1", "s_mode", s_mode, 1);
    check("R1", "ps_mode", ps_mode, 0);
    check("R1", "cwp", cwp, 0);
    check("R1", "tbr", tbr, 0);
    check("R1", "err_mode", err_mode, 0);
    check("R1", "redir_valid", redir_valid, 0);
    check("R1", "cap_valid", cap_valid, 0);
    rst_n = 1'b1;

    drive("R7", 0, 0, 0, 8'h0, 1, 8'h21, 0, 0, 20'h0, 0);       // masked async
    drive("R11", 0, 0, 0, 8'h0, 0, 8'h0, 0, 1, 20'h40000, 0);   // base load
    drive("R8", 0, 0, 1, 8'h05, 0, 8'h0, 0, 0, 20'h0, 0);       // sync with et=0
    drive("R8", 0, 0, 0, 8'h0, 1, 8'h21, 1, 1, 20'h12345, 1);   // ignored in error
    drive("R8", 0, 1, 0, 8'h0, 0, 8'h0, 0, 0, 20'h0, 0);
    drive("R6", 1, 0, 0, 8'h0, 0, 8'h0, 0, 0, 20'h0, 0);        // leave error
    drive("R10", 0, 0, 0, 8'h0, 0, 8'h0, 1, 0, 20'h0, 0);       // enable traps
    drive("R2", 0, 0, 0, 8'h0, 1, 8'h11, 0, 0, 20'h0, 0);       // async trap
    drive("R5", 0, 0, 1, 8'h22, 1, 8'h33, 1, 0, 20'h0, 0);      // stalled, ignored
    drive("R5", 0, 0, 0, 8'h0, 0, 8'h0, 0, 0, 20'h0, 1);        // handshake
    idle("R5", 0);
    for (int i = 0; i < NW; i++) drive("R10", 0, 0, 0, 8'h0, 0, 8'h0, 1, 0, 20'h0, 0);
    drive("R3", 0, 0, 0, 8'h0, 1, 8'h30, 0, 0, 20'h0, 1);       // cwp 0 -> 7
    idle("R3", 1);
    drive("R10", 0, 0, 0, 8'h0, 0, 8'h0, 1, 0, 20'h0, 0);       // cwp 7 -> 0
    drive("R9", 0, 1, 1, 8'h44, 1, 8'h55, 1, 0, 20'h0, 1);      // misalign wins
    idle("R9", 1);
    drive("R10", 0, 0, 0, 8'h0, 0, 8'h0, 1, 0, 20'h0, 0);
    drive("R9", 0, 0, 1, 8'h44, 1, 8'h55, 0, 0, 20'h0, 1);      // sync over async
    idle("R9", 1);
    drive("R10", 0, 0, 0, 8'h0, 0, 8'h0, 1, 0, 20'h0, 0);
    drive("R11", 0, 0, 0, 8'h0, 1, 8'h66, 0, 1, 20'hABCDE, 1);  // base write lost to trap
    idle("R4", 1);
    drive("R10", 0, 0, 0, 8'h0, 0, 8'h0, 1, 0, 20'h0, 0);
    drive("R6", 0, 0, 0, 8'h0, 1, 8'h12, 0, 0, 20'h0, 0);       // trap, capture pending
    drive("R6", 1, 0, 0, 8'h0, 0, 8'h0, 0, 0, 20'h0, 0);        // reset drops it
    drive("R10", 0, 0, 0, 8'h0, 0, 8'h0, 1, 0, 20'h0, 0);
    drive("R6", 1, 1, 1, 8'h44, 1, 8'h55, 1, 1, 20'h11111, 0);  // reset wins
    drive("R7", 0, 0, 0, 8'h0, 1, 8'h77, 0, 0, 20'h0, 0);
    idle("R7", 0);
    idle("R7", 0);
    check("R4", "redirects left", 64'(exp_redir.size()), 64'd0);
    check("R5", "captures left", 64'(exp_cap.size()), 64'd0);
    summary();
    $finish;
  end
endmodule